// File: doc/BRIEF.md
# Edge-Select Input Capture Unit

This block takes a snapshot of a free-running timer value when a selected transition arrives on an external, asynchronous event pin. The pin is brought into the clock domain by a synchronizer. The qualifying edge type is chosen by a two-bit mode: none, rising, falling or both. The snapshot can go to either of two read-only capture registers. In first-event mode the first qualifying edge is stored in the first register. In second-event mode the first qualifying edge is only counted, and the second one is stored in the second register.

Each capture raises a sticky status flag for the neighbouring interrupt logic and gives a one-cycle capture pulse. While the flag is set, the unit ignores further edges. A status-clear strobe drops the flag and re-arms the internal event count. The shared pin is used only while the pin-direction input says it is an input. The counter and the register bus live outside this block. All pins are plain level or strobe signals: no data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure to respect.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted and right after it, `cap_first`, `cap_second`, `cap_flag` and `cap_pulse` are all zero.
- R2: With `edge_mode` = 1, a low-to-high change of `evt_pin` qualifies. The capture happens at the third rising clock edge after the pin change and takes the `cnt_val` present at that clock edge. `cap_pulse` is high for exactly the one cycle in which the capture register takes the new value.
- R3: With `second_sel` = 0, the first qualifying edge since the unit was armed is written to `cap_first`. Later edges leave both registers unchanged until the flag is cleared.
- R4: With `edge_mode` = 2, only high-to-low changes of `evt_pin` qualify.
- R5: With `second_sel` = 1, the first qualifying edge since arming is only counted. The second qualifying edge is written to `cap_second`, and `cap_first` is never written.
- R6: With `edge_mode` = 3, changes in both directions qualify.
- R7: Every capture sets `cap_flag`, which stays set until `flag_clr` is high for a clock. A clear also resets the event count. When a clear and a qualifying edge fall in the same cycle, the clear wins and that edge is dropped.
- R8: With `edge_mode` = 0, no edge is captured or counted.
- R9: While `pin_is_input` is 0, edges on `evt_pin` are neither captured nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pin | input | 1 | Asynchronous external event input |
| cnt_val | input | CNT_W | Current timer counter value |
| edge_mode | input | 2 | 0 none, 1 rising, 2 falling, 3 both |
| second_sel | input | 1 | 0 store first event in `cap_first`, 1 store second event in `cap_second` |
| pin_is_input | input | 1 | 1 when the shared pin is configured as an input |
| flag_clr | input | 1 | Clears the capture flag and re-arms the event count |
| cap_first | output | CNT_W | First-event capture register |
| cap_second | output | CNT_W | Second-event capture register |
| cap_flag | output | 1 | Sticky capture status flag |
| cap_pulse | output | 1 | One-cycle pulse on each capture |

## Verification
A wrong event count shows up at the ports at the very next qualifying edge in second-event mode. The capture then lands one edge early or one edge late, and `cap_second` holds a counter value that is off by the spacing between edges. A stuck or mis-set flag shows up on the next edge in either of two ways: a capture that should have happened is missing, or a register is overwritten while the flag is high. A synchronizer of the wrong depth shifts every captured value by a multiple of the counter step, so the first capture after reset already exposes it.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_t;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level,
  output logic level_prev
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin_async;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign level      = chain[LAST-1];
  assign level_prev = chain[LAST];
endmodule

// File: rtl/ecap_edge.sv
module ecap_edge
  import ecap_pkg::*;
(
  input  logic      level,
  input  logic      level_prev,
  input  edge_sel_t mode,
  input  logic      enable,
  output logic      hit
);
  logic rise, fall;

  assign rise = level & ~level_prev;
  assign fall = ~level & level_prev;

  always_comb begin
    hit = 1'b0;
    if (enable) begin
      unique case (mode)
        EDGE_OFF:  hit = 1'b0;
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_ANY:  hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ecap_ctrl.sv
module ecap_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             second_sel,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] reg_first,
  output logic [CNT_W-1:0] reg_second,
  output logic             flag,
  output logic             pulse
);
  logic seen_one;
  logic take_first, take_second, accept;

  assign accept      = hit & ~flag & ~clr;
  assign take_first  = accept & ~second_sel;
  assign take_second = accept & second_sel & seen_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_first  <= '0;
      reg_second <= '0;
      flag       <= 1'b0;
      pulse      <= 1'b0;
      seen_one   <= 1'b0;
    end else begin
      pulse <= take_first | take_second;
      if (take_first)  reg_first  <= cnt_val;
      if (take_second) reg_second <= cnt_val;
      if (clr) begin
        flag     <= 1'b0;
        seen_one <= 1'b0;
      end else if (take_first || take_second) begin
        flag     <= 1'b1;
        seen_one <= 1'b0;
      end else if (accept && second_sel) begin
        seen_one <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pin,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [1:0]       edge_mode,
  input  logic             second_sel,
  input  logic             pin_is_input,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_first,
  output logic [CNT_W-1:0] cap_second,
  output logic             cap_flag,
  output logic             cap_pulse
);
  logic lvl, lvl_prev, hit;

  ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (evt_pin),
    .level      (lvl),
    .level_prev (lvl_prev)
  );

  ecap_edge u_edge (
    .level      (lvl),
    .level_prev (lvl_prev),
    .mode       (edge_sel_t'(edge_mode)),
    .enable     (pin_is_input),
    .hit        (hit)
  );

  ecap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .second_sel (second_sel),
    .clr        (flag_clr),
    .cnt_val    (cnt_val),
    .reg_first  (cap_first),
    .reg_second (cap_second),
    .flag       (cap_flag),
    .pulse      (cap_pulse)
  );
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       edge_mode,
  input logic             second_sel,
  input logic             pin_is_input,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cap_first,
  input logic [CNT_W-1:0] cap_second,
  input logic             cap_flag,
  input logic             cap_pulse
);
  assert_pulse_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> cap_flag);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!cap_flag && !cap_pulse));

  assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'd0) |=> !cap_pulse);

  assert_pin_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input |=> !cap_pulse);

  assert_first_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_first) |-> (cap_pulse && !$past(second_sel)));

  assert_second_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_second) |-> (cap_pulse && $past(second_sel)));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
endmodule

bind edge_capture_unit ecap_checker #(.CNT_W(CNT_W)) u_ecap_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .edge_mode    (edge_mode),
  .second_sel   (second_sel),
  .pin_is_input (pin_is_input),
  .flag_clr     (flag_clr),
  .cap_first    (cap_first),
  .cap_second   (cap_second),
  .cap_flag     (cap_flag),
  .cap_pulse    (cap_pulse)
);

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         evt_pin = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic [1:0]   edge_mode = 2'd0;
  logic         second_sel = 1'b0;
  logic         pin_is_input = 1'b1;
  logic         flag_clr = 1'b0;
  logic [W-1:0] cap_first, cap_second;
  logic         cap_flag, cap_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state
  logic [W-1:0] m_first = '0, m_second = '0;
  logic m_flag = 0, m_pulse = 0, m_seen = 0;
  logic h1 = 0, h2 = 0, h3 = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt_val <= cnt_val + 32'd7;

  edge_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .cnt_val(cnt_val),
    .edge_mode(edge_mode), .second_sel(second_sel), .pin_is_input(pin_is_input),
    .flag_clr(flag_clr), .cap_first(cap_first), .cap_second(cap_second),
    .cap_flag(cap_flag), .cap_pulse(cap_pulse)
  );

  function automatic logic qualifies(input logic [1:0] md, input logic old_v, input logic new_v);
    case (md)
      2'd1: return !old_v && new_v;
      2'd2: return old_v && !new_v;
      2'd3: return old_v != new_v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge with inputs already set; advances one clock and compares.
  task automatic cyc();
    logic q;
    logic [W-1:0] c;
    c = cnt_val;
    q = qualifies(edge_mode, h3, h2) && pin_is_input;
    m_pulse = 1'b0;
    if (flag_clr) begin
      m_flag = 1'b0; m_seen = 1'b0;
    end else if (q && !m_flag) begin
      if (!second_sel) begin
        m_first = c; m_flag = 1'b1; m_pulse = 1'b1;
      end else if (!m_seen) begin
        m_seen = 1'b1;
      end else begin
        m_second = c; m_flag = 1'b1; m_pulse = 1'b1; m_seen = 1'b0;
      end
    end
    h3 = h2; h2 = h1; h1 = evt_pin;
    @(negedge clk);
    chk("R3 cap_first",  cap_first,  m_first);
    chk("R5 cap_second", cap_second, m_second);
    chk("R7 cap_flag",   {31'd0, cap_flag},  {31'd0, m_flag});
    chk("R2 cap_pulse",  {31'd0, cap_pulse}, {31'd0, m_pulse});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    #500us;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] c0;
    repeat (3) @(negedge clk);
    chk("R1 reset cap_first",  cap_first, '0);
    chk("R1 reset cap_second", cap_second, '0);
    chk("R1 reset flag",  {31'd0, cap_flag},  32'd0);
    chk("R1 reset pulse", {31'd0, cap_pulse}, 32'd0);
    rst_n = 1'b1;
    idle(3);

    // R2: rising edge latency and value
    edge_mode = 2'd1; idle(2);
    c0 = cnt_val; evt_pin = 1'b1;
    cyc(); cyc(); cyc();
    chk("R2 latency value", cap_first, c0 + 32'd14);
    chk("R2 pulse at capture", {31'd0, cap_pulse}, 32'd1);
    // R3: further edges ignored while flag set
    idle(2); evt_pin = 1'b0; idle(3); evt_pin = 1'b1; idle(5);
    chk("R3 held value", cap_first, c0 + 32'd14);
    clear_flag();
    // R2: falling edge in rising mode ignored
    evt_pin = 1'b0; idle(6);
    chk("R2 falling ignored flag", {31'd0, cap_flag}, 32'd0);

    // R4: falling mode
    edge_mode = 2'd2; evt_pin = 1'b1; idle(6);
    chk("R4 rise ignored", {31'd0, cap_flag}, 32'd0);
    evt_pin = 1'b0; idle(6);
    chk("R4 fall captured", {31'd0, cap_flag}, 32'd1);
    clear_flag();

    // R6: both edges
    edge_mode = 2'd3; evt_pin = 1'b1; idle(6);
    chk("R6 rise captured", {31'd0, cap_flag}, 32'd1);
    clear_flag();
    evt_pin = 1'b0; idle(6);
    chk("R6 fall captured", {31'd0, cap_flag}, 32'd1);
    clear_flag();

    // R5: second-event mode
    edge_mode = 2'd1; second_sel = 1'b1;
    evt_pin = 1'b1; idle(5); evt_pin = 1'b0; idle(5);
    chk("R5 first event only counted", {31'd0, cap_flag}, 32'd0);
    evt_pin = 1'b1; idle(6);
    chk("R5 second event captured", {31'd0, cap_flag}, 32'd1);
    clear_flag();
    evt_pin = 1'b0; idle(4);

    // R8: mode off
    edge_mode = 2'd0; evt_pin = 1'b1; idle(5); evt_pin = 1'b0; idle(5);
    chk("R8 no capture", {31'd0, cap_flag}, 32'd0);

    // R9: pin as output, edges not counted
    edge_mode = 2'd1; pin_is_input = 1'b0;
    evt_pin = 1'b1; idle(5); evt_pin = 1'b0; idle(5);
    pin_is_input = 1'b1; idle(2);
    evt_pin = 1'b1; idle(6);
    chk("R9 edge not counted", {31'd0, cap_flag}, 32'd0);
    evt_pin = 1'b0; idle(4);

    // R7 and all modes: constrained random against the model
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) begin
        edge_mode    = 2'($urandom_range(0, 3));
        second_sel   = 1'($urandom_range(0, 1));
        pin_is_input = ($urandom_range(0, 7) != 0);
      end
      if ($urandom_range(0, 3) == 0) evt_pin = ~evt_pin;
      flag_clr = ($urandom_range(0, 11) == 0);
      cyc();
    end
    flag_clr = 1'b0;
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule